// File: doc/BRIEF.md
# Free-Running Compare Timer with Toggle Outputs

This block is a 16-bit up-counter that, once started, advances on every cycle in which the count-clock enable is high. It has two compare channels. Whenever the counter steps onto a channel's compare value, that channel raises a single-cycle interrupt pulse and inverts its output pin. Software can use these pins as square-wave or event-marker outputs.

When the counter steps past its maximum value, it wraps to zero and emits a one-cycle overflow interrupt. The wrap also sets an overflow flag, which holds until software writes a clear.

Software reaches the block through a small write-only register port:
- a control word that starts and stops counting and clears the flag;
- one word per compare channel.

Compare values take effect in the very cycle they are written, with no shadow buffer. Starting the counter inverts both output pins at once. Stopping it returns the count to zero and leaves the pins at their present levels.

Top module: `frt_cmp_timer`

## Requirements
- R1: After reset the count is 0, both toggle outputs are 0, no interrupt is asserted, the overflow flag is 0 and the counter is stopped.
- R2: Writing control bit 0 = 1 while stopped starts the counter: the count is forced to 0, both toggle outputs invert, and a count tick in that cycle is not counted. Writing bit 0 = 1 while already running has no effect on count or outputs.
- R3: While running, the count rises by exactly 1 for each cycle with tick_en high and is unchanged otherwise. While stopped, ticks are ignored.
- R4: On a counted tick whose new count equals a channel's compare value, that channel's cmp_irq is high for exactly the following cycle and its toggle output inverts. The other channel is unaffected.
- R5: A compare write applies at once: if the write coincides with a tick, the tick is compared against the written value. A compare value written equal to the present count does not match until the counter steps onto it again.
- R6: A counted tick while the count is 16'hFFFF sets the count to 0 and makes ovf_irq high for exactly one cycle.
- R7: ovf_flag is set together with ovf_irq and stays 1 until control bit 1 is written as 1. If a clear and a new overflow fall in the same cycle, the flag ends up 1.
- R8: Writing control bit 0 = 0 while running stops the counter and forces the count to 0, even if a tick occurs in that cycle. The toggle outputs keep their levels and no interrupt is raised.
- R9: Register map on wr_addr: 0 is control (bit 0 run, bit 1 write-1 flag clear), 1 is the channel 0 compare value, 2 is the channel 1 compare value. Writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | Count-clock enable; one count step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Register write data |
| count | output | 16 | Present counter value |
| tgl_out | output | 2 | Toggle outputs, bit i for channel i |
| cmp_irq | output | 2 | Compare-match interrupt pulses, bit i for channel i |
| ovf_irq | output | 1 | Overflow interrupt pulse |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Two pairs of functions can meet in one cycle, and the bench provokes both.

The first pair is an overflow and a software clear of the flag. The bench runs the counter up to 16'hFFFF and then issues the control write that clears the flag in the same cycle as the wrapping tick. It expects the overflow pulse and the flag to read 1 afterwards; a further clear on its own then drops the flag.

The second pair is a compare write and a counted tick. The bench writes a compare value equal to the next count together with a tick, and expects the match to fire on that tick. A compare value of 0 is also held across the wrap, so that a match and the overflow pulse appear together.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned NUM_CH   = 2;
  localparam int unsigned ADDR_W   = $clog2(NUM_CH + 2);
  localparam int unsigned CTRL_ADR = 0;
  localparam int unsigned CMP_BASE = 1;
  localparam int unsigned RUN_BIT  = 0;
  localparam int unsigned CLR_BIT  = 1;
endpackage

// File: rtl/frt_ctrl.sv
module frt_ctrl
  import frt_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          wrap_evt,
  output logic          run_q,
  output logic          start,
  output logic          stop,
  output logic          flag_q
);
  localparam logic [AW-1:0] CTRL_A = AW'(CTRL_ADR);

  logic ctrl_wr;
  logic clr_req;
  logic run_d;
  logic flag_d;

  always_comb begin
    ctrl_wr = wr_en && (wr_addr == CTRL_A);
    clr_req = ctrl_wr && wr_data[CLR_BIT];
    start   = ctrl_wr && wr_data[RUN_BIT] && !run_q;
    stop    = ctrl_wr && !wr_data[RUN_BIT] && run_q;
    run_d   = run_q;
    if (start) run_d = 1'b1;
    if (stop)  run_d = 1'b0;
    flag_d  = flag_q;
    if (clr_req)  flag_d = 1'b0;
    if (wrap_evt) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      flag_q <= flag_d;
    end
  end

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_req) |=> flag_q);
  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> flag_q);
endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         start,
  input  logic         stop,
  input  logic         tick,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt,
  output logic         adv,
  output logic         wrap_evt,
  output logic         ovf_q
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt_d;

  always_comb begin
    adv      = run && tick && !start && !stop;
    cnt_nxt  = cnt_q + 1'b1;
    wrap_evt = adv && (cnt_q == MAXV);
    cnt_d    = cnt_q;
    if (start || stop) cnt_d = '0;
    else if (adv)      cnt_d = cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= wrap_evt;
    end
  end

  // R6
  ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (cnt_q == '0));
  // R8
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (cnt_q == '0 && !ovf_q));
endmodule

// File: rtl/frt_cmp_chan.sv
module frt_cmp_chan #(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = 2,
  parameter logic [AW-1:0] SEL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          adv,
  input  logic          start,
  input  logic [W-1:0]  cnt_nxt,
  output logic          irq_q,
  output logic          tgl_q
);
  logic         sel_wr;
  logic [W-1:0] cmp_q;
  logic [W-1:0] cmp_eff;
  logic         hit;
  logic         tgl_d;

  always_comb begin
    sel_wr  = wr_en && (wr_addr == SEL);
    cmp_eff = sel_wr ? wr_data : cmp_q;
    hit     = adv && (cnt_nxt == cmp_eff);
    tgl_d   = (start || hit) ? !tgl_q : tgl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      irq_q <= 1'b0;
      tgl_q <= 1'b0;
    end else begin
      if (sel_wr) cmp_q <= wr_data;
      irq_q <= hit;
      tgl_q <= tgl_d;
    end
  end

  // R2
  start_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (tgl_q != $past(tgl_q)));
  // R4
  irq_tgl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (tgl_q != $past(tgl_q)));
endmodule

// File: rtl/frt_cmp_timer.sv
module frt_cmp_timer
  import frt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  count,
  output logic [NUM_CH-1:0] tgl_out,
  output logic [NUM_CH-1:0] cmp_irq,
  output logic              ovf_irq,
  output logic              ovf_flag
);
  logic [1:0]       rst_sync;
  logic             rst_i_n;
  logic             run_q;
  logic             start;
  logic             stop;
  logic             adv;
  logic             wrap_evt;
  logic [CNT_W-1:0] cnt_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  frt_ctrl #(.AW(ADDR_W), .DW(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wrap_evt (wrap_evt),
    .run_q    (run_q),
    .start    (start),
    .stop     (stop),
    .flag_q   (ovf_flag)
  );

  frt_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .run      (run_q),
    .start    (start),
    .stop     (stop),
    .tick     (tick_en),
    .cnt_q    (count),
    .cnt_nxt  (cnt_nxt),
    .adv      (adv),
    .wrap_evt (wrap_evt),
    .ovf_q    (ovf_irq)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] CH_A = ADDR_W'(CMP_BASE + i);
    frt_cmp_chan #(.W(CNT_W), .AW(ADDR_W), .SEL(CH_A)) u_ch (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .adv     (adv),
      .start   (start),
      .cnt_nxt (cnt_nxt),
      .irq_q   (cmp_irq[i]),
      .tgl_q   (tgl_out[i])
    );
  end
endmodule

// File: tb/frt_cmp_timer_test.sv
module frt_cmp_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic [1:0]  tgl_out;
  logic [1:0]  cmp_irq;
  logic        ovf_irq;
  logic        ovf_flag;

  int total = 0;
  int fails = 0;
  int cyc = 0;

  frt_cmp_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .count(count),
    .tgl_out(tgl_out), .cmp_irq(cmp_irq), .ovf_irq(ovf_irq), .ovf_flag(ovf_flag)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 195000) begin
      total++; fails++;
      $display("FAIL watchdog: run hung, cycles %0d expected < %0d", cyc, 195000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [1:0] a, input logic [15:0] d, input logic t);
    wr_en = w; wr_addr = a; wr_data = d; tick_en = t;
    @(posedge clk); #1;
    wr_en = 1'b0; tick_en = 1'b0;
  endtask

  // {wr, addr, data, tick, exp_count, exp_tgl, exp_cirq, exp_oirq}
  localparam int NV = 19;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 2'd1, 16'd3, 1'b0, 16'd0, 2'b00, 2'b00, 1'b0}, // R9 cmp0=3
    {1'b1, 2'd2, 16'd5, 1'b0, 16'd0, 2'b00, 2'b00, 1'b0}, // R9 cmp1=5
    {1'b1, 2'd0, 16'd1, 1'b0, 16'd0, 2'b11, 2'b00, 1'b0}, // R2 start
    {1'b0, 2'd0, 16'd0, 1'b1, 16'd1, 2'b11, 2'b00, 1'b0}, // R3
    {1'b0, 2'd0, 16'd0, 1'b0, 16'd1, 2'b11, 2'b00, 1'b0}, // R3 no tick
    {1'b0, 2'd0, 16'd0, 1'b1, 16'd2, 2'b11, 2'b00, 1'b0}, // R3
    {1'b0, 2'd0, 16'd0, 1'b1, 16'd3, 2'b10, 2'b01, 1'b0}, // R4 ch0 match
    {1'b0, 2'd0, 16'd0, 1'b1, 16'd4, 2'b10, 2'b00, 1'b0}, // R4 pulse ends
    {1'b1, 2'd2, 16'd4, 1'b0, 16'd4, 2'b10, 2'b00, 1'b0}, // R5 cmp1=count
    {1'b0, 2'd0, 16'd0, 1'b1, 16'd5, 2'b10, 2'b00, 1'b0}, // R5 no match
    {1'b1, 2'd1, 16'd6, 1'b1, 16'd6, 2'b11, 2'b01, 1'b0}, // R5 bypass
    {1'b0, 2'd0, 16'd0, 1'b1, 16'd7, 2'b11, 2'b00, 1'b0}, // R3
    {1'b1, 2'd0, 16'd0, 1'b1, 16'd0, 2'b11, 2'b00, 1'b0}, // R8 stop
    {1'b0, 2'd0, 16'd0, 1'b1, 16'd0, 2'b11, 2'b00, 1'b0}, // R3 stopped
    {1'b1, 2'd1, 16'd1, 1'b0, 16'd0, 2'b11, 2'b00, 1'b0}, // R9
    {1'b1, 2'd2, 16'd1, 1'b0, 16'd0, 2'b11, 2'b00, 1'b0}, // R9
    {1'b1, 2'd0, 16'd1, 1'b1, 16'd0, 2'b00, 2'b00, 1'b0}, // R2 restart
    {1'b0, 2'd0, 16'd0, 1'b1, 16'd1, 2'b11, 2'b11, 1'b0}, // R4 both
    {1'b1, 2'd0, 16'd1, 1'b1, 16'd2, 2'b11, 2'b00, 1'b0}  // R2 no effect
  };

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 tgl", tgl_out, 0);
    chk("R1 cmp_irq", cmp_irq, 0);
    chk("R1 ovf_irq", ovf_irq, 0);
    chk("R1 flag", ovf_flag, 0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][40], VEC[i][39:38], VEC[i][37:22], VEC[i][21]);
      chk($sformatf("R2-R5,R8 vec%0d count", i), count, VEC[i][20:5]);
      chk($sformatf("R4 vec%0d tgl", i), tgl_out, VEC[i][4:3]);
      chk($sformatf("R4 vec%0d cmp_irq", i), cmp_irq, VEC[i][2:1]);
      chk($sformatf("R6 vec%0d ovf_irq", i), ovf_irq, VEC[i][0]);
    end

    // Wrap with cmp0 at max and cmp1 at zero
    drive(1'b1, 2'd1, 16'hFFFF, 1'b0);
    drive(1'b1, 2'd2, 16'h0000, 1'b0);
    while (count != 16'hFFFE) drive(1'b0, 2'd0, 16'd0, 1'b1);
    drive(1'b0, 2'd0, 16'd0, 1'b1);
    chk("R4 count max", count, 16'hFFFF);
    chk("R4 ch0 at max irq", cmp_irq, 2'b01);
    chk("R4 ch0 at max tgl", tgl_out, 2'b10);
    chk("R6 no early ovf", ovf_irq, 0);
    drive(1'b0, 2'd0, 16'd0, 1'b1);
    chk("R6 wrap count", count, 0);
    chk("R6 ovf pulse", ovf_irq, 1);
    chk("R7 flag set", ovf_flag, 1);
    chk("R4 ch1 at zero irq", cmp_irq, 2'b10);
    chk("R4 ch1 at zero tgl", tgl_out, 2'b00);
    drive(1'b0, 2'd0, 16'd0, 1'b0);
    chk("R6 pulse one cycle", ovf_irq, 0);
    chk("R7 flag sticky", ovf_flag, 1);
    drive(1'b1, 2'd0, 16'd3, 1'b0);
    chk("R7 flag cleared", ovf_flag, 0);
    chk("R2 run rewrite count", count, 0);
    chk("R2 run rewrite tgl", tgl_out, 2'b00);
    drive(1'b1, 2'd3, 16'hFFFF, 1'b1);
    chk("R9 addr3 ignored count", count, 1);
    chk("R9 addr3 ignored tgl", tgl_out, 2'b00);
    chk("R9 addr3 ignored flag", ovf_flag, 0);

    // Clear collides with overflow
    while (count != 16'hFFFF) drive(1'b0, 2'd0, 16'd0, 1'b1);
    chk("R4 second max tgl", tgl_out, 2'b01);
    drive(1'b1, 2'd0, 16'd3, 1'b1);
    chk("R6 second wrap", ovf_irq, 1);
    chk("R7 set wins over clear", ovf_flag, 1);
    chk("R4 ch1 second zero tgl", tgl_out, 2'b11);
    drive(1'b1, 2'd0, 16'd3, 1'b0);
    chk("R7 later clear", ovf_flag, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule